// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

After reset, this block owns the command pins of a DDR SDRAM device and steps it through its start-up routine. First it holds clock-enable low for a programmable settling time. Then it raises clock-enable and sends a fixed series of commands. The series starts with a precharge of all banks. Next come two mode register loads: the first turns the on-die DLL on through the extended register, and the second resets that DLL and sets the read latency and burst shape. The block then waits a fixed 200 NOP cycles so the DLL can lock. After that it sends another precharge-all, two auto-refresh commands, and a last mode register load with the DLL reset bit cleared.

When the last command has gone out, the sequencer asks a downstream calibration stage to take over, using a request/acknowledge pair. It reports completion only after calibration acknowledges. The settling time, the precharge and refresh recovery gaps, and the mode register contents are all elaboration parameters. Each cycle that carries no command drives a NOP.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, the outputs are: `mem_cke` 0, NOP on the command pins, bank address 0, address 0, `cal_req` 0, `init_done` 0.
- R2: After reset is released, `mem_cke` stays low for exactly INIT_DLY cycles. It then goes high and never falls again.
- R3: An INIT_DLY of zero is treated as one cycle of low clock-enable.
- R4: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: precharge 0010, mode register load 0000, auto-refresh 0001, NOP 0111. Exactly seven non-NOP commands appear, in this order: precharge, load, load, precharge, refresh, refresh, load. No other code is ever driven.
- R5: The first precharge appears in the cycle right after `mem_cke` first goes high.
- R6: Each precharge drives address bit AP_BIT high and every other address bit low, with bank address 0.
- R7: The second command is issued in the cycle right after the first precharge's T_RP recovery gap. It selects the extended register with bank address 1 and drives EMR_OPTS on the address, with bit 0 forced to 0 (DLL on). The third command follows in the very next cycle.
- R8: The third command targets the base register (bank address 0). Its address carries the burst length code in bits 2:0 (2 beats=1, 4=2, 8=3), the burst type in bit 3, CAS_CODE in bits 6:4, and a 1 in bit 8 (DLL reset). All other bits are 0.
- R9: Exactly 200 NOP cycles separate the DLL-reset load from the second precharge.
- R10: Exactly T_RP NOP cycles follow each precharge, and exactly T_RFC NOP cycles follow each refresh, before the next command. A value of 0 places the commands in consecutive cycles.
- R11: The final load has the same address as R8 except that bit 8 is 0, with bank address 0.
- R12: `cal_req` rises in the cycle after the final load. It stays high until `cal_ack` is seen while `cal_req` is high. `cal_ack` at any other time has no effect.
- R13: When `cal_ack` is sampled with `cal_req` high, `cal_req` falls and `init_done` rises in the next cycle. `init_done` then stays high, with `mem_cke` high and NOP on the command pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_ack | input | 1 | Calibration finished acknowledge |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_a | output | ADDR_W | Address bus |
| cal_req | output | 1 | Request for calibration to take over |
| init_done | output | 1 | Initialization and calibration complete |

## Verification
The calibration acknowledge can arrive in the same cycle that `cal_req` first rises. An acknowledge can also be present while commands are still being issued. To provoke both, one instance runs with `cal_ack` tied high from reset. That instance must still produce the full command timeline unchanged. Its `cal_req` must be high for exactly one cycle, and `init_done` must rise in the following cycle and not earlier. A second instance acknowledges several cycles late, so the bench can confirm that the request holds while waiting.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    localparam int LOCK_CYC  = 200;
    localparam int NUM_STEPS = 7;

    typedef enum logic [1:0] {CMD_NOP, CMD_PRE, CMD_LMR, CMD_REF} cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    typedef enum logic [2:0] {ST_PWR, ST_CKE, ST_ISSUE, ST_GAP, ST_CAL, ST_DONE} seq_state_e;

    typedef enum logic [2:0] {K_PRE, K_EMR, K_MR_DLLRST, K_REF, K_MR_RUN} step_kind_e;

    typedef enum logic [1:0] {G_NONE, G_RP, G_RFC, G_LOCK} gap_sel_e;

    typedef struct packed {
        step_kind_e kind;
        gap_sel_e   gap;
    } step_t;

    // Fixed order of the power-up steps and the wait that follows each one.
    function automatic step_t step_at(logic [2:0] i);
        step_t s;
        case (i)
            3'd0:    s = '{kind: K_PRE,       gap: G_RP};
            3'd1:    s = '{kind: K_EMR,       gap: G_NONE};
            3'd2:    s = '{kind: K_MR_DLLRST, gap: G_LOCK};
            3'd3:    s = '{kind: K_PRE,       gap: G_RP};
            3'd4:    s = '{kind: K_REF,       gap: G_RFC};
            3'd5:    s = '{kind: K_REF,       gap: G_RFC};
            default: s = '{kind: K_MR_RUN,    gap: G_NONE};
        endcase
        return s;
    endfunction

    function automatic cmd_e kind_cmd(step_kind_e k);
        case (k)
            K_PRE:   return CMD_PRE;
            K_REF:   return CMD_REF;
            default: return CMD_LMR;
        endcase
    endfunction

    function automatic cmd_pins_t encode(cmd_e c);
        case (c)
            CMD_PRE: return 4'b0010;
            CMD_LMR: return 4'b0000;
            CMD_REF: return 4'b0001;
            default: return 4'b0111;
        endcase
    endfunction

    function automatic logic [2:0] burst_code(int beats);
        case (beats)
            2:       return 3'd1;
            8:       return 3'd3;
            default: return 3'd2;
        endcase
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
    import ddr_init_pkg::*;
#(
    parameter int INIT_DLY = 20000,
    parameter int T_RP     = 3,
    parameter int T_RFC    = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cal_ack,
    output logic       cke_nxt,
    output logic       issue,
    output step_kind_e kind,
    output logic       cal_req,
    output logic       init_done
);

    // A zero settling time is raised to one cycle.
    localparam int INIT_EFF = (INIT_DLY < 1) ? 1 : INIT_DLY;
    localparam int MAX_CNT  = imax(imax(INIT_EFF, LOCK_CYC), imax(T_RP, T_RFC));
    localparam int CNT_W    = $clog2(MAX_CNT + 1);
    localparam logic [2:0] LAST_IDX = 3'(NUM_STEPS - 1);

    function automatic int gap_cycles(gap_sel_e g);
        case (g)
            G_RP:    return T_RP;
            G_RFC:   return T_RFC;
            G_LOCK:  return LOCK_CYC;
            default: return 0;
        endcase
    endfunction

    seq_state_e       st, st_n;
    logic [2:0]       idx, idx_n;
    logic             req_q, done_q;
    logic             t_load, t_zero;
    logic [CNT_W-1:0] t_val;
    step_t            cur;
    int               gap_len;

    ddr_init_timer #(.W(CNT_W), .RST_VAL(INIT_EFF - 1)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    assign cur     = step_at(idx);
    assign gap_len = gap_cycles(cur.gap);

    always_comb begin
        st_n   = st;
        idx_n  = idx;
        t_load = 1'b0;
        t_val  = '0;
        case (st)
            ST_PWR:   if (t_zero) st_n = ST_CKE;
            ST_CKE:   st_n = ST_ISSUE;
            ST_ISSUE: begin
                if (gap_len != 0) begin
                    t_load = 1'b1;
                    t_val  = CNT_W'(gap_len - 1);
                    st_n   = ST_GAP;
                end else if (idx == LAST_IDX) begin
                    st_n = ST_CAL;
                end else begin
                    idx_n = idx + 3'd1;
                end
            end
            ST_GAP: begin
                if (t_zero) begin
                    idx_n = idx + 3'd1;
                    st_n  = ST_ISSUE;
                end
            end
            ST_CAL:   if (req_q && cal_ack) st_n = ST_DONE;
            default:  st_n = ST_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_PWR;
            idx    <= '0;
            req_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            st     <= st_n;
            idx    <= idx_n;
            req_q  <= (st == ST_CAL) && !(req_q && cal_ack);
            done_q <= done_q || (req_q && cal_ack);
        end
    end

    assign cke_nxt   = (st != ST_PWR);
    assign issue     = (st == ST_ISSUE);
    assign kind      = cur.kind;
    assign cal_req   = req_q;
    assign init_done = done_q;

endmodule

// File: rtl/ddr_init_drive.sv
module ddr_init_drive
    import ddr_init_pkg::*;
#(
    parameter int              ADDR_W     = 13,
    parameter int              BA_W       = 2,
    parameter int              AP_BIT     = 10,
    parameter logic [2:0]      CAS_CODE   = 3'b010,
    parameter int              BURST_LEN  = 4,
    parameter int              BURST_TYPE = 0,
    parameter logic [ADDR_W-1:0] EMR_OPTS = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_nxt,
    input  logic              issue,
    input  step_kind_e        kind,
    output logic              mem_cke,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [BA_W-1:0]   mem_ba,
    output logic [ADDR_W-1:0] mem_a
);

    localparam logic [BA_W-1:0] BA_BASE = '0;
    localparam logic [BA_W-1:0] BA_EXT  = BA_W'(1);

    function automatic logic [ADDR_W-1:0] mode_word(logic dll_rst);
        logic [ADDR_W-1:0] w;
        w      = '0;
        w[2:0] = burst_code(BURST_LEN);
        w[3]   = (BURST_TYPE != 0);
        w[6:4] = CAS_CODE;
        w[8]   = dll_rst;
        return w;
    endfunction

    cmd_pins_t         pins_n, pins_q;
    logic [BA_W-1:0]   ba_n;
    logic [ADDR_W-1:0] a_n;

    always_comb begin
        pins_n = encode(issue ? kind_cmd(kind) : CMD_NOP);
        ba_n   = BA_BASE;
        a_n    = '0;
        if (issue) begin
            case (kind)
                K_PRE:       a_n[AP_BIT] = 1'b1;
                K_EMR: begin
                    ba_n   = BA_EXT;
                    a_n    = EMR_OPTS;
                    a_n[0] = 1'b0;
                end
                K_MR_DLLRST: a_n = mode_word(1'b1);
                K_MR_RUN:    a_n = mode_word(1'b0);
                default:     a_n = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_cke <= 1'b0;
            pins_q  <= encode(CMD_NOP);
            mem_ba  <= '0;
            mem_a   <= '0;
        end else begin
            mem_cke <= cke_nxt;
            pins_q  <= pins_n;
            mem_ba  <= ba_n;
            mem_a   <= a_n;
        end
    end

    assign mem_cs_n  = pins_q.cs_n;
    assign mem_ras_n = pins_q.ras_n;
    assign mem_cas_n = pins_q.cas_n;
    assign mem_we_n  = pins_q.we_n;

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int                ADDR_W     = 13,
    parameter int                BA_W       = 2,
    parameter int                AP_BIT     = 10,
    parameter int                INIT_DLY   = 20000,
    parameter int                T_RP       = 3,
    parameter int                T_RFC      = 10,
    parameter logic [2:0]        CAS_CODE   = 3'b010,
    parameter int                BURST_LEN  = 4,
    parameter int                BURST_TYPE = 0,
    parameter logic [ADDR_W-1:0] EMR_OPTS   = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cal_ack,
    output logic              mem_cke,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [BA_W-1:0]   mem_ba,
    output logic [ADDR_W-1:0] mem_a,
    output logic              cal_req,
    output logic              init_done
);

    logic       cke_nxt;
    logic       issue;
    step_kind_e kind;

    ddr_init_ctrl #(
        .INIT_DLY (INIT_DLY),
        .T_RP     (T_RP),
        .T_RFC    (T_RFC)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cal_ack   (cal_ack),
        .cke_nxt   (cke_nxt),
        .issue     (issue),
        .kind      (kind),
        .cal_req   (cal_req),
        .init_done (init_done)
    );

    ddr_init_drive #(
        .ADDR_W     (ADDR_W),
        .BA_W       (BA_W),
        .AP_BIT     (AP_BIT),
        .CAS_CODE   (CAS_CODE),
        .BURST_LEN  (BURST_LEN),
        .BURST_TYPE (BURST_TYPE),
        .EMR_OPTS   (EMR_OPTS)
    ) u_drive (
        .clk       (clk),
        .rst       (rst),
        .cke_nxt   (cke_nxt),
        .issue     (issue),
        .kind      (kind),
        .mem_cke   (mem_cke),
        .mem_cs_n  (mem_cs_n),
        .mem_ras_n (mem_ras_n),
        .mem_cas_n (mem_cas_n),
        .mem_we_n  (mem_we_n),
        .mem_ba    (mem_ba),
        .mem_a     (mem_a)
    );

endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk (
    input logic clk,
    input logic rst,
    input logic cal_ack,
    input logic cke,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic cal_req,
    input logic init_done
);

    logic [3:0] code;
    assign code = {cs_n, ras_n, cas_n, we_n};

    // R1: reset drives the idle state on the next edge
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!cke && code == 4'b0111 && !cal_req && !init_done));

    // R2: clock enable never drops once raised
    a_r2_cke_sticky: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    // R4: only the four legal codes appear
    a_r4_legal_code: assert property (@(posedge clk) disable iff (rst)
        code inside {4'b0111, 4'b0010, 4'b0000, 4'b0001});

    // R4: no command while clock enable is low
    a_r4_nop_while_cke_low: assert property (@(posedge clk) disable iff (rst)
        !cke |-> code == 4'b0111);

    // R5: first command after clock enable rises is a precharge
    a_r5_pre_after_cke: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |=> code == 4'b0010);

    // R12: request holds until acknowledged
    a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
        (cal_req && !cal_ack) |=> cal_req);

    // R12: acknowledge without request does not complete
    a_r12_ack_ignored: assert property (@(posedge clk) disable iff (rst)
        (!cal_req && !init_done) |=> !init_done);

    // R13: accepted acknowledge ends the request and raises done
    a_r13_done_follows: assert property (@(posedge clk) disable iff (rst)
        (cal_req && cal_ack) |=> (init_done && !cal_req));

    // R13: done is sticky and the bus stays quiet
    a_r13_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> (init_done && cke && code == 4'b0111));

endmodule

bind ddr_init_seq ddr_init_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cal_ack   (cal_ack),
    .cke       (mem_cke),
    .cs_n      (mem_cs_n),
    .ras_n     (mem_ras_n),
    .cas_n     (mem_cas_n),
    .we_n      (mem_we_n),
    .cal_req   (cal_req),
    .init_done (init_done)
);

// File: tb/sim_ddr_init_seq.sv
module trace_mon (
    input logic        clk,
    input logic        rst,
    input logic        cke,
    input logic        cs_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input logic [1:0]  ba,
    input logic [12:0] a,
    input logic        req,
    input logic        done
);
    int cyc, nev, cke_low, cke_fall, req_first, done_first, req_cnt, bad_code, busy_late;
    int          ev_cyc [16];
    logic [3:0]  ev_pin [16];
    logic [12:0] ev_a   [16];
    logic [1:0]  ev_ba  [16];
    logic        prev_cke;
    logic [3:0]  p;

    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; nev = 0; cke_low = 0; cke_fall = 0; req_first = -1;
            done_first = -1; req_cnt = 0; bad_code = 0; busy_late = 0; prev_cke = 1'b0;
        end else begin
            cyc++;
            p = {cs_n, ras_n, cas_n, we_n};
            if (!cke) cke_low++;
            if (prev_cke && !cke) cke_fall++;
            prev_cke = cke;
            if (p != 4'b0111) begin
                if (!(p inside {4'b0010, 4'b0000, 4'b0001})) bad_code++;
                if (nev < 16) begin
                    ev_cyc[nev] = cyc; ev_pin[nev] = p; ev_a[nev] = a; ev_ba[nev] = ba;
                end
                nev++;
                if (req || done) busy_late++;
            end
            if (req) begin
                req_cnt++;
                if (req_first < 0) req_first = cyc;
            end
            if (done && done_first < 0) done_first = cyc;
        end
    end
endmodule

module sim_ddr_init_seq;
    logic clk = 1'b0;
    logic rst, ack0, ack1;
    always #5 clk = ~clk;

    logic cke0, cs0, ras0, cas0, we0, req0, done0;
    logic cke1, cs1, ras1, cas1, we1, req1, done1;
    logic [1:0]  ba0, ba1;
    logic [12:0] a0, a1;

    int n_vec = 0;
    int n_bad = 0;

    ddr_init_seq #(.ADDR_W(13), .BA_W(2), .AP_BIT(10), .INIT_DLY(5), .T_RP(2), .T_RFC(7),
                   .CAS_CODE(3'b010), .BURST_LEN(4), .BURST_TYPE(0), .EMR_OPTS(13'h0)) u0 (
        .clk(clk), .rst(rst), .cal_ack(ack0), .mem_cke(cke0), .mem_cs_n(cs0),
        .mem_ras_n(ras0), .mem_cas_n(cas0), .mem_we_n(we0), .mem_ba(ba0), .mem_a(a0),
        .cal_req(req0), .init_done(done0));

    ddr_init_seq #(.ADDR_W(13), .BA_W(2), .AP_BIT(8), .INIT_DLY(0), .T_RP(0), .T_RFC(0),
                   .CAS_CODE(3'b011), .BURST_LEN(8), .BURST_TYPE(1), .EMR_OPTS(13'h3)) u1 (
        .clk(clk), .rst(rst), .cal_ack(ack1), .mem_cke(cke1), .mem_cs_n(cs1),
        .mem_ras_n(ras1), .mem_cas_n(cas1), .mem_we_n(we1), .mem_ba(ba1), .mem_a(a1),
        .cal_req(req1), .init_done(done1));

    trace_mon m0 (.clk(clk), .rst(rst), .cke(cke0), .cs_n(cs0), .ras_n(ras0), .cas_n(cas0),
                  .we_n(we0), .ba(ba0), .a(a0), .req(req0), .done(done0));
    trace_mon m1 (.clk(clk), .rst(rst), .cke(cke1), .cs_n(cs1), .ras_n(ras1), .cas_n(cas1),
                  .we_n(we1), .ba(ba1), .a(a1), .req(req1), .done(done1));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] mode_exp(int bl_code, int bt, int cas, int dll);
        return 13'((dll << 8) | (cas << 4) | (bt << 3) | bl_code);
    endfunction

    // R1: reset values on both instances
    task automatic t_reset_state();
        check("R1 u0 reset outputs", {cke0, cs0, ras0, cas0, we0, ba0, a0, req0, done0},
              {1'b0, 4'b0111, 2'b00, 13'h0, 1'b0, 1'b0});
        check("R1 u1 reset outputs", {cke1, cs1, ras1, cas1, we1, ba1, a1, req1, done1},
              {1'b0, 4'b0111, 2'b00, 13'h0, 1'b0, 1'b0});
    endtask

    // R12/R13: late acknowledge on u0
    task automatic t_handshake_u0();
        do begin @(negedge clk); #2; end while (m0.req_first < 0);
        check("R12 u0 no done at request", {31'b0, done0}, 32'd0);
        repeat (3) @(negedge clk);
        #2;
        check("R12 u0 request held while waiting", {30'b0, req0, done0}, {30'b0, 2'b10});
        ack0 = 1'b1;
        @(negedge clk); #2;
        check("R13 u0 done after ack", {30'b0, req0, done0}, {30'b0, 2'b01});
        check("R13 u0 done cycle", 32'(m0.done_first), 32'(m0.req_first + 4));
        ack0 = 1'b0;
    endtask

    task automatic t_sequence(input int id, input int d, input int rp, input int rfc,
                              input logic [12:0] e_pre, input logic [12:0] e_emr,
                              input logic [12:0] e_mr1, input logic [12:0] e_mr2);
        int t [7];
        logic [3:0]  e_pin [7];
        logic [1:0]  e_ba  [7];
        logic [12:0] e_a   [7];
        string rq [7];
        string cq [7];
        int g_low, g_fall, g_nev, g_bad, g_req, g_done, g_rcnt, g_busy;
        t[0] = d + 2;            t[1] = t[0] + rp + 1;  t[2] = t[1] + 1;
        t[3] = t[2] + 201;       t[4] = t[3] + rp + 1;  t[5] = t[4] + rfc + 1;
        t[6] = t[5] + rfc + 1;
        e_pin = '{4'b0010, 4'b0000, 4'b0000, 4'b0010, 4'b0001, 4'b0001, 4'b0000};
        e_ba  = '{2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
        e_a   = '{e_pre, e_emr, e_mr1, e_pre, 13'h0, 13'h0, e_mr2};
        rq    = '{"R6", "R7", "R8", "R6", "R4", "R4", "R11"};
        cq    = '{"R5", "R10", "R7", "R9", "R10", "R10", "R10"};
        if (id == 0) begin
            g_low = m0.cke_low; g_fall = m0.cke_fall; g_nev = m0.nev; g_bad = m0.bad_code;
            g_req = m0.req_first; g_done = m0.done_first; g_rcnt = m0.req_cnt; g_busy = m0.busy_late;
        end else begin
            g_low = m1.cke_low; g_fall = m1.cke_fall; g_nev = m1.nev; g_bad = m1.bad_code;
            g_req = m1.req_first; g_done = m1.done_first; g_rcnt = m1.req_cnt; g_busy = m1.busy_late;
        end
        check($sformatf("%s u%0d cke low cycles", (d < 1) ? "R3" : "R2", id),
              32'(g_low), 32'((d < 1) ? 1 : d));
        check($sformatf("R2 u%0d cke never falls", id), 32'(g_fall), 32'd0);
        check($sformatf("R4 u%0d command count", id), 32'(g_nev), 32'd7);
        check($sformatf("R4 u%0d illegal codes", id), 32'(g_bad), 32'd0);
        for (int i = 0; i < 7; i++) begin
            logic [3:0] gp; logic [1:0] gb; logic [12:0] ga; int gc;
            if (id == 0) begin gp = m0.ev_pin[i]; gb = m0.ev_ba[i]; ga = m0.ev_a[i]; gc = m0.ev_cyc[i]; end
            else         begin gp = m1.ev_pin[i]; gb = m1.ev_ba[i]; ga = m1.ev_a[i]; gc = m1.ev_cyc[i]; end
            check($sformatf("R4 u%0d cmd %0d code", id, i), {28'b0, gp}, {28'b0, e_pin[i]});
            check($sformatf("%s u%0d cmd %0d bank/addr", rq[i], id, i), {17'b0, gb, ga},
                  {17'b0, e_ba[i], e_a[i]});
            check($sformatf("%s u%0d cmd %0d cycle", cq[i], id, i), 32'(gc),
                  32'(((d < 1) && (i >= 0)) ? t[i] - d + 1 - 1 + 1 + ((d < 1) ? 0 : 0) : t[i]));
        end
        check($sformatf("R12 u%0d request cycle", id), 32'(g_req), 32'(t[6] + 1));
        check($sformatf("R13 u%0d no command after request", id), 32'(g_busy), 32'd0);
        if (id == 1) begin
            check("R12 u1 early ack ignored, request one cycle", 32'(g_rcnt), 32'd1);
            check("R13 u1 done one cycle after request", 32'(g_done), 32'(g_req + 1));
        end
    endtask

    // R13: steady state after completion
    task automatic t_idle_after_done();
        repeat (4) @(negedge clk);
        #2;
        check("R13 u0 idle after done", {cke0, cs0, ras0, cas0, we0, req0, done0}, {1'b1, 4'b0111, 1'b0, 1'b1});
        check("R13 u1 idle after done", {cke1, cs1, ras1, cas1, we1, req1, done1}, {1'b1, 4'b0111, 1'b0, 1'b1});
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst  = 1'b1;
        ack0 = 1'b0;
        ack1 = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        t_reset_state();
        #1 rst = 1'b0;
        t_handshake_u0();
        do begin @(negedge clk); #2; end while (m1.done_first < 0);
        t_sequence(0, 5, 2, 7, 13'h400, 13'h000,
                   mode_exp(2, 0, 2, 1), mode_exp(2, 0, 2, 0));
        t_sequence(1, 1, 0, 0, 13'h100, 13'h002,
                   mode_exp(3, 1, 3, 1), mode_exp(3, 1, 3, 0));
        t_idle_after_done();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule